// File: doc/BRIEF.md
# SPI Memory Slave Front End

This block is the serial front end of a memory device that answers on an SPI bus in mode 0. It watches an active-low chip select, the serial clock, the serial data input and an active-low hold input. All four are oversampled by a fast system clock through a small synchronizer. The block assembles incoming bits into bytes, most significant bit first, and hands each byte to a downstream command decoder with a one-cycle strobe. In the other direction it takes the byte the decoder offers and shifts it out on the serial data output. An output-enable goes with that output so the pad can be tri-stated.

The hold input pauses a sequence in mid-byte without losing its place. A pause takes effect at once when hold drops while the serial clock is low. When hold drops while the clock is high, the pause waits for the next clock fall. Leaving a pause needs hold to rise while the clock is low. Raising chip select ends the sequence and clears any pause, so the next sequence starts on a byte boundary. After reset, no sequence is accepted until chip select has gone through a fresh high-to-low transition.

Every serial input passes `SYNC_STAGES` flops before it is used. A level on a serial pin must therefore hold for more than `SYNC_STAGES + 2` system clocks to be seen.

Top module: `spi_mem_front`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `miso_oe`, `rx_valid`, `tx_load` and `frame_active` are 0.
- R2: A sequence starts only on a high-to-low transition of `cs_n` seen after reset. If `cs_n` is already low when reset ends, clock edges are ignored until `cs_n` goes high and then low again.
- R3: `cs_n` high drives `miso_oe` and `frame_active` to 0 and discards any partly received byte. The first byte of the next sequence is assembled from its first eight clock rises.
- R4: `mosi` is sampled on each rising edge of `sck`, most significant bit first. After every eighth accepted rise, `rx_valid` pulses for one system clock with the assembled byte on `rx_data`.
- R5: `miso` sends `tx_data` most significant bit first. `tx_data` is loaded when a sequence starts and at the `sck` fall that follows each eighth accepted rise, with a one-cycle `tx_load` pulse each time. Every other accepted fall shifts to the next bit, so each bit is valid before the following rise.
- R6: `hold_n` falling while `sck` is low pauses the sequence at once.
- R7: `hold_n` falling while `sck` is high pauses the sequence at the next `sck` fall, and that fall still advances `miso`. If `hold_n` rises again before that fall, no pause occurs.
- R8: While paused, `sck` and `mosi` transitions are ignored: no byte strobe is raised and the bit position is kept.
- R9: A pause ends only when `hold_n` rises while `sck` is low. A rise while `sck` is high leaves the block paused until `hold_n` falls and rises again with `sck` low.
- R10: `miso_oe` is 0 whenever `hold_n` is low and for the whole of a pause. While the block is selected and running, it is 1.
- R11: Raising `cs_n` during a pause ends the sequence and clears the pause. The next sequence runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the bus master |
| mosi | input | 1 | Serial data into the device |
| hold_n | input | 1 | Pause request, active low |
| miso | output | 1 | Serial data out of the device (0 when not enabled) |
| miso_oe | output | 1 | Output enable for the serial data pad |
| frame_active | output | 1 | High while a sequence is selected |
| rx_data | output | BYTE_W | Last assembled byte |
| rx_valid | output | 1 | One-cycle strobe, a byte is on rx_data |
| tx_data | input | BYTE_W | Byte to send next, supplied by the decoder |
| tx_load | output | 1 | One-cycle strobe, tx_data has been taken |

## Verification
The hardest case to reach is a deferred pause. Hold drops in the high half of a clock bit, the following clock fall must still shift the output, and the later release then comes while the clock is high and must be refused. The bench reaches this by moving `hold_n` in the middle of a clock phase and holding each level for longer than the synchronizer delay. It then clocks junk pulses while paused and finishes the byte after the true release. A wrongly accepted or wrongly dropped edge shows up as a corrupted received byte, an extra strobe, or a wrong transmitted bit.

// File: rtl/spi_fe_pkg.sv
// Package: shared types of the SPI memory front end.
package spi_fe_pkg;
    // Pause state of a selected sequence.
    typedef enum logic [1:0] {
        HS_RUN    = 2'd0,
        HS_ARMED  = 2'd1,
        HS_PAUSED = 2'd2
    } hold_st_e;
endpackage

// File: rtl/spi_fe_sync.sv
// Module: spi_fe_sync
// Purpose: brings asynchronous serial pins into the system clock domain.
// Assumes: STAGES >= 1; RST_VAL sets the value each bit shows during reset.
module spi_fe_sync #(
    parameter int WIDTH = 4,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int CHAIN_W = WIDTH * STAGES;

    logic [CHAIN_W-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Single flop stage per bit.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= d;
            end
        end else begin : g_multi
            // Shift chain, newest sample in the low slice.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[CHAIN_W-WIDTH-1:0], d};
            end
        end
    endgenerate

    assign q = chain[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/spi_fe_hold.sv
// Module: spi_fe_hold
// Purpose: pause/resume state of a selected sequence driven by the hold pin.
// Assumes: inputs are synchronized; sck_fall is a one-cycle pulse; a
// deselect (sel low) clears any pause.
module spi_fe_hold
    import spi_fe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic sck_s,
    input  logic sck_fall,
    input  logic hold_s,
    output logic run_ok,
    output logic fall_ok,
    output logic paused
);
    hold_st_e st_q, st_d;
    logic     hold_q;

    // Next pause state from hold level/edge and clock level.
    always_comb begin
        st_d = st_q;
        if (!sel) begin
            st_d = HS_RUN;
        end else begin
            case (st_q)
                HS_RUN:    if (!hold_s) st_d = sck_s ? HS_ARMED : HS_PAUSED;
                HS_ARMED:  if (hold_s) st_d = HS_RUN;
                           else if (sck_fall) st_d = HS_PAUSED;
                HS_PAUSED: if (hold_s && !hold_q && !sck_s) st_d = HS_RUN;
                default:   st_d = HS_RUN;
            endcase
        end
    end

    // State and hold history registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= HS_RUN;
            hold_q <= 1'b1;
        end else begin
            st_q   <= st_d;
            hold_q <= hold_s;
        end
    end

    assign run_ok  = (st_q == HS_RUN);
    assign fall_ok = (st_q != HS_PAUSED);
    assign paused  = (st_q == HS_PAUSED);

    // R9: leaving a pause while selected needs the clock low
    p_resume_sck_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == HS_PAUSED && sel) |=> (st_q == HS_PAUSED) || !$past(sck_s));

    // R7: a deferred pause begins only on a clock fall
    p_armed_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == HS_ARMED && sel) |=> (st_q != HS_PAUSED) || $past(sck_fall));

    // R11: deselect always clears the pause
    p_desel_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !paused);
endmodule

// File: rtl/spi_fe_shift.sv
// Module: spi_fe_shift
// Purpose: receive and transmit shift registers with the bit counter.
// Assumes: rise_en/fall_en are one-cycle pulses already qualified by
// selection and pause; start pulses while sel is still low.
module spi_fe_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              start,
    input  logic              rise_en,
    input  logic              fall_en,
    input  logic              mosi_s,
    input  logic [BYTE_W-1:0] tx_data,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              tx_load,
    output logic              so_bit
);
    localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;

    // Receive side: shift in on accepted rises, strobe on each full byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (!sel) begin
                bit_cnt <= '0;
            end else if (rise_en) begin
                rx_sh <= {rx_sh[BYTE_W-2:0], mosi_s};
                if (bit_cnt == LAST) begin
                    bit_cnt  <= '0;
                    rx_data  <= {rx_sh[BYTE_W-2:0], mosi_s};
                    rx_valid <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    // Transmit side: load at start and on byte boundaries, else shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh   <= '0;
            tx_load <= 1'b0;
        end else begin
            tx_load <= 1'b0;
            if (start) begin
                tx_sh   <= tx_data;
                tx_load <= 1'b1;
            end else if (!sel) begin
                tx_sh <= '0;
            end else if (fall_en) begin
                if (bit_cnt == '0) begin
                    tx_sh   <= tx_data;
                    tx_load <= 1'b1;
                end else begin
                    tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    assign so_bit = tx_sh[BYTE_W-1];

    // R8: the bit position moves only on an accepted rise
    p_cnt_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !rise_en) |=> $stable(bit_cnt));

    // R4: a byte strobe lands on a byte boundary and lasts one cycle
    p_valid_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (bit_cnt == '0));
    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
endmodule

// File: rtl/spi_mem_front.sv
// Module: spi_mem_front
// Purpose: SPI mode-0 slave front end of a memory device, with hold-based
// pause and resume. Delivers received bytes to a decoder and sends the
// decoder's bytes back.
// Assumes: serial pin levels hold for more than SYNC_STAGES+2 clk cycles.
module spi_mem_front #(
    parameter int BYTE_W = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              mosi,
    input  logic              hold_n,
    output logic              miso,
    output logic              miso_oe,
    output logic              frame_active,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              tx_load
);
    import spi_fe_pkg::*;

    // Pin order in the synchronizer: {hold, data, clock, select}.
    localparam int PINS = 4;
    // Select resets as "low" so a select already low at reset gives no edge.
    localparam logic [PINS-1:0] PIN_RST = 4'b1000;

    logic [PINS-1:0] pins_s;
    logic cs_s, sck_s, mosi_s, hold_s;
    logic cs_q, sck_q, sel;
    logic start, sck_rise, sck_fall;
    logic run_ok, fall_ok, paused;
    logic rise_en, fall_en, so_bit;

    spi_fe_sync #(
        .WIDTH  (PINS),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({hold_n, mosi, sck, cs_n}),
        .q    (pins_s)
    );

    assign cs_s   = pins_s[0];
    assign sck_s  = pins_s[1];
    assign mosi_s = pins_s[2];
    assign hold_s = pins_s[3];

    assign start    = cs_q & ~cs_s;
    assign sck_rise = sck_s & ~sck_q;
    assign sck_fall = ~sck_s & sck_q;

    // Edge history and selection: set on a select fall, cleared on high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q  <= 1'b0;
            sck_q <= 1'b0;
            sel   <= 1'b0;
        end else begin
            cs_q  <= cs_s;
            sck_q <= sck_s;
            if (cs_s)       sel <= 1'b0;
            else if (start) sel <= 1'b1;
        end
    end

    spi_fe_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .sck_s   (sck_s),
        .sck_fall(sck_fall),
        .hold_s  (hold_s),
        .run_ok  (run_ok),
        .fall_ok (fall_ok),
        .paused  (paused)
    );

    assign rise_en = sel & run_ok & sck_rise;
    assign fall_en = sel & fall_ok & sck_fall;

    spi_fe_shift #(
        .BYTE_W(BYTE_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .start   (start),
        .rise_en (rise_en),
        .fall_en (fall_en),
        .mosi_s  (mosi_s),
        .tx_data (tx_data),
        .rx_data (rx_data),
        .rx_valid(rx_valid),
        .tx_load (tx_load),
        .so_bit  (so_bit)
    );

    assign miso_oe      = sel & hold_s & ~paused;
    assign miso         = miso_oe & so_bit;
    assign frame_active = sel;

    // R2: no byte strobe unless selected the cycle before
    p_strobe_needs_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !rx_valid);

    // R10: a low hold pin (from the synchronizer) keeps the pad released
    p_hiz_on_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_s |-> !miso_oe);

    // R3: deselect releases the pad on the next cycle
    p_desel_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !miso_oe);
endmodule

// File: tb/test_spi_mem_front.sv
// Bench: drives SPI mode-0 sequences with hold pauses; a loopback decoder
// model returns each received byte XOR A5, the first byte is 3C.
module test_spi_mem_front;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b0, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1;
    logic miso, miso_oe, frame_active, rx_valid, tx_load;
    logic [7:0] rx_data;
    logic [7:0] tx_data = 8'h3C;

    int n_chk = 0, n_err = 0;
    int rx_cnt = 0, rx_base = 0, load_cnt = 0;
    logic [7:0] rx_last = '0;
    logic [7:0] so_byte = '0;
    logic [7:0] exp_tx = 8'h3C;

    spi_mem_front i_spi_mem_front (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .hold_n(hold_n), .miso(miso), .miso_oe(miso_oe),
        .frame_active(frame_active), .rx_data(rx_data), .rx_valid(rx_valid),
        .tx_data(tx_data), .tx_load(tx_load)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Decoder model and strobe monitor.
    always @(posedge clk) begin
        if (cs_n) tx_data <= 8'h3C;
        else if (rx_valid) tx_data <= rx_data ^ 8'hA5;
        if (rx_valid) begin
            rx_cnt  <= rx_cnt + 1;
            rx_last <= rx_data;
        end
        if (tx_load) load_cnt <= load_cnt + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_h();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic bit_io(input logic b);
        mosi = b;
        wait_h();
        so_byte = {so_byte[6:0], miso};
        sck = 1'b1;
        wait_h();
        sck = 1'b0;
    endtask

    task automatic junk();
        mosi = ~mosi;
        wait_h();
        sck = 1'b1;
        wait_h();
        sck = 1'b0;
        wait_h();
    endtask

    task automatic bits(input logic [7:0] d, input int hi, input int lo);
        if (hi == 7) rx_base = rx_cnt;
        for (int i = hi; i >= lo; i--) bit_io(d[i]);
    endtask

    task automatic byte_done(input logic [7:0] d, input string tag);
        wait_h();
        chk(rx_cnt == rx_base + 1 && rx_last == d, {tag, " rx byte"}, rx_last, d);
        chk(so_byte == exp_tx, {tag, " miso byte"}, so_byte, exp_tx);
        exp_tx = d ^ 8'hA5;
    endtask

    task automatic begin_frame();
        cs_n = 1'b0;
        wait_h();
        exp_tx = 8'h3C;
    endtask

    task automatic end_frame();
        wait_h();
        cs_n = 1'b1;
        wait_h();
        wait_h();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R4 watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        int l0;
        // R1: reset state, with select already low (for R2)
        repeat (5) @(negedge clk);
        chk(!miso_oe && !rx_valid && !tx_load && !frame_active, "R1 in reset",
            {miso_oe, rx_valid, tx_load, frame_active}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!miso_oe && !rx_valid && !frame_active, "R1 after reset",
            {miso_oe, rx_valid, frame_active}, 0);

        // R2: select low since reset, clock edges must be ignored
        bits(8'hA7, 7, 0);
        wait_h();
        chk(rx_cnt == 0 && !frame_active && !miso_oe, "R2 no sequence", rx_cnt, 0);
        cs_n = 1'b1;
        wait_h();
        begin_frame();
        chk(frame_active && miso_oe, "R2 fresh select", {frame_active, miso_oe}, 3);
        bits(8'h4D, 7, 0);
        byte_done(8'h4D, "R2");
        end_frame();
        chk(!miso_oe && !frame_active, "R3 deselect", {miso_oe, frame_active}, 0);

        // R4 R5: sweep all byte values in one sequence
        l0 = load_cnt;
        begin_frame();
        for (int v = 0; v < 256; v++) begin
            bits(v[7:0], 7, 0);
            byte_done(v[7:0], "R4 R5 sweep");
        end
        end_frame();
        chk(load_cnt == l0 + 257, "R5 tx_load count", load_cnt - l0, 257);

        // R6 R8 R10: pause with clock low, junk clocks, release with clock low
        begin_frame();
        bits(8'h96, 7, 5);
        hold_n = 1'b0;
        wait_h();
        chk(!miso_oe, "R10 hold low", miso_oe, 0);
        repeat (4) junk();
        chk(rx_cnt == rx_base, "R8 paused no strobe", rx_cnt - rx_base, 0);
        hold_n = 1'b1;
        wait_h();
        chk(miso_oe, "R6 resumed", miso_oe, 1);
        bits(8'h96, 4, 0);
        byte_done(8'h96, "R6 R8");

        // R7: hold falls with clock high, pause on the next fall
        bits(8'h5B, 7, 3);
        mosi = 1'b0;
        wait_h();
        so_byte = {so_byte[6:0], miso};
        sck = 1'b1;
        wait_h();
        hold_n = 1'b0;
        wait_h();
        chk(!miso_oe, "R10 hold low clock high", miso_oe, 0);
        sck = 1'b0;
        wait_h();
        repeat (3) junk();
        chk(rx_cnt == rx_base, "R7 paused no strobe", rx_cnt - rx_base, 0);
        hold_n = 1'b1;
        wait_h();
        bits(8'h5B, 1, 0);
        byte_done(8'h5B, "R7");

        // R9: release with clock high is refused
        bits(8'hC3, 7, 4);
        hold_n = 1'b0;
        wait_h();
        sck = 1'b1;
        wait_h();
        hold_n = 1'b1;
        wait_h();
        sck = 1'b0;
        wait_h();
        chk(!miso_oe, "R9 still paused", miso_oe, 0);
        repeat (2) junk();
        chk(rx_cnt == rx_base, "R9 paused no strobe", rx_cnt - rx_base, 0);
        hold_n = 1'b0;
        wait_h();
        hold_n = 1'b1;
        wait_h();
        chk(miso_oe, "R9 resumed", miso_oe, 1);
        bits(8'hC3, 3, 0);
        byte_done(8'hC3, "R9");

        // R7: hold pulse inside the high phase is cancelled
        bits(8'h71, 7, 6);
        mosi = 1'b1;
        wait_h();
        so_byte = {so_byte[6:0], miso};
        sck = 1'b1;
        wait_h();
        hold_n = 1'b0;
        wait_h();
        hold_n = 1'b1;
        wait_h();
        sck = 1'b0;
        wait_h();
        chk(miso_oe, "R7 cancelled pause", miso_oe, 1);
        bits(8'h71, 4, 0);
        byte_done(8'h71, "R7 cancel");

        // R3: deselect mid-byte, next byte aligned
        bits(8'hFF, 7, 5);
        end_frame();
        begin_frame();
        bits(8'h12, 7, 0);
        byte_done(8'h12, "R3 realign");

        // R11: deselect during a pause
        bits(8'h0F, 7, 4);
        hold_n = 1'b0;
        wait_h();
        cs_n = 1'b1;
        wait_h();
        hold_n = 1'b1;
        wait_h();
        wait_h();
        chk(!frame_active && !miso_oe, "R11 ended", {frame_active, miso_oe}, 0);
        begin_frame();
        chk(miso_oe, "R11 pause cleared", miso_oe, 1);
        bits(8'hE4, 7, 0);
        byte_done(8'hE4, "R11");
        end_frame();

        finish_run();
    end
endmodule